// File: doc/BRIEF.md
# Scanline-Counting Interrupt Timer

This block turns a stream of video sync events into a periodic CPU interrupt. Each horizontal sync strobe advances a six-bit line counter. When that counter completes a fixed period of lines, it returns to zero and the interrupt request goes high. The request stays high until the CPU acknowledges it or a clear strobe arrives.

Two mechanisms keep the interrupt cadence tied to the frame. First, a vertical sync strobe arms a short countdown, measured in lines. When the countdown runs out, the counter is cleared. If the counter had got far enough by then, an interrupt is raised as well. Second, an acknowledge drops the upper half of the count, which shortens the interval to the next interrupt when the acknowledge comes late.

A read strobe records the request level that the CPU has seen. A changed flag stays high while the live request differs from that recorded level. All inputs are single-cycle strobes sampled on the rising clock edge.

Top module: `scanline_irq_timer`

## Requirements
- R1: After the asynchronous reset (`rst_n` low), `irqReq` and `irqChanged` are both 0 and the line count is 0.
- R2: Each `hsyncTick` adds one to the line count. The strobe that brings the count to 52 sets it back to 0 and sets `irqReq` in the following cycle. Starting from a count of 0, exactly 52 strobes are needed.
- R3: `ackTick` clears `irqReq` and clears bit 5 (weight 32) of the line count. With the count at 40, an acknowledge leaves 8, so the next request comes 44 strobes later.
- R4: `vsyncTick` loads a line countdown with 2. Each later `hsyncTick` decrements it while it is non-zero. On the strobe that brings it to 0, the counter is cleared, and `irqReq` is set if the count after that strobe's increment is 32 or more.
- R5: If the count is below 32 when the countdown expires, no request is raised, but the counter is still cleared. The next request then needs a full 52 strobes.
- R6: If the count reaches 52 on the same strobe that the countdown expires, the counter ends at 0 and a single request is raised.
- R7: `clearTick` clears the line count and `irqReq`. An `hsyncTick` in the same cycle is ignored.
- R8: If `ackTick` arrives in the same cycle as a strobe that would raise the request, the acknowledge wins: `irqReq` stays 0 and the count is 0.
- R9: `readTick` records the value `irqReq` had before that clock edge. `irqChanged` is 1 whenever `irqReq` differs from the recorded value.
- R10: A `vsyncTick` while a countdown is running reloads it to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsyncTick | input | 1 | One-cycle strobe per horizontal sync edge |
| vsyncTick | input | 1 | One-cycle strobe at the leading edge of vertical sync |
| ackTick | input | 1 | One-cycle interrupt acknowledge |
| clearTick | input | 1 | One-cycle clear of count and request |
| readTick | input | 1 | One-cycle strobe recording the request level as read |
| irqReq | output | 1 | Interrupt request level |
| irqChanged | output | 1 | Request differs from the level last read |

## Verification
The embedded assertions check the following on every cycle:
- the line count never reaches the period;
- an acknowledge or clear always leaves the request low, with bit 5 cleared;
- a vertical sync always leaves the countdown at 2;
- the request only rises after a horizontal sync;
- a quiet read drops the changed flag.

The directed scenarios are needed for the timing properties, which depend on counting behaviour over many strobes:
- the exact 52-strobe period;
- the interval shortened by a late acknowledge;
- the two-line realignment with and without an interrupt;
- the coincident wrap and expiry;
- the priority cases.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

  // Per-cycle commands from control to datapath.
  typedef struct packed {
    logic step;       // apply one line advance
    logic zeroCount;  // the advance ends with the counter at zero
    logic raise;      // set the request
    logic ack;        // acknowledge: drop request and the high count bit
    logic clear;      // clear counter and request
  } ctrlStrobes_t;

endpackage

// File: rtl/scanline_irq_ctrl.sv
module scanline_irq_ctrl
  import scanline_irq_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int WRAP   = 52,
  parameter int THRESH = 32,
  parameter int LOAD   = 2,
  parameter int DOWN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsyncTick,
  input  logic             vsyncTick,
  input  logic             ackTick,
  input  logic             clearTick,
  input  logic [CNT_W-1:0] lineCount,
  output ctrlStrobes_t     strobes
);

  localparam logic [CNT_W:0]    WrapVal   = (CNT_W+1)'(WRAP);
  localparam logic [CNT_W:0]    ThreshVal = (CNT_W+1)'(THRESH);
  localparam logic [DOWN_W-1:0] LoadVal   = DOWN_W'(LOAD);
  localparam logic [DOWN_W-1:0] OneVal    = DOWN_W'(1);

  logic [DOWN_W-1:0] downCnt;
  logic              step;
  logic [CNT_W:0]    bumped;
  logic [CNT_W:0]    afterStep;
  logic              wrapHit;
  logic              expire;
  logic              expireRaise;

  // A clear cycle ignores any horizontal sync in the same cycle.
  assign step        = hsyncTick & ~clearTick;
  assign bumped      = {1'b0, lineCount} + 1'b1;
  assign wrapHit     = step && (bumped == WrapVal);
  assign afterStep   = wrapHit ? '0 : bumped;
  assign expire      = step && (downCnt == OneVal);
  assign expireRaise = expire && (afterStep >= ThreshVal);

  always_comb begin
    strobes.step      = step;
    strobes.zeroCount = wrapHit | expire;
    strobes.raise     = wrapHit | expireRaise;
    strobes.ack       = ackTick;
    strobes.clear     = clearTick;
  end

  // Realignment countdown, measured in lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     downCnt <= '0;
    else if (vsyncTick)             downCnt <= LoadVal;
    else if (step && downCnt != '0) downCnt <= downCnt - 1'b1;
  end

  assert_vsync_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vsyncTick |=> (downCnt == LoadVal));

  assert_count_below_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, lineCount} < WrapVal));

  assert_countdown_moves_on_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsyncTick && !step) |=> $stable(downCnt));

endmodule

// File: rtl/scanline_irq_datapath.sv
module scanline_irq_datapath
  import scanline_irq_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int ACK_BIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  input  logic             readTick,
  output logic [CNT_W-1:0] lineCount,
  output logic             irqReq,
  output logic             irqChanged
);

  logic [CNT_W-1:0] nextCount;
  logic             lastRead;

  always_comb begin
    nextCount = lineCount;
    if (strobes.step) nextCount = strobes.zeroCount ? '0 : lineCount + 1'b1;
    if (strobes.ack)  nextCount[ACK_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineCount <= '0;
      irqReq    <= 1'b0;
    end else if (strobes.clear) begin
      lineCount <= '0;
      irqReq    <= 1'b0;
    end else begin
      lineCount <= nextCount;
      if (strobes.ack)        irqReq <= 1'b0;
      else if (strobes.raise) irqReq <= 1'b1;
    end
  end

  // The read captures the level the CPU saw before this edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lastRead <= 1'b0;
    else if (readTick) lastRead <= irqReq;
  end

  assign irqChanged = irqReq ^ lastRead;

  assert_ack_drops_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.ack |=> (!irqReq && !lineCount[ACK_BIT]));

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clear |=> (!irqReq && lineCount == '0));

  assert_quiet_read_settles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (readTick && !strobes.raise && !strobes.ack && !strobes.clear) |=> !irqChanged);

endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
  import scanline_irq_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int WRAP    = 52,
  parameter int THRESH  = 32,
  parameter int ACK_BIT = 5,
  parameter int LOAD    = 2,
  parameter int DOWN_W  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsyncTick,
  input  logic vsyncTick,
  input  logic ackTick,
  input  logic clearTick,
  input  logic readTick,
  output logic irqReq,
  output logic irqChanged
);

  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] lineCount;

  scanline_irq_ctrl #(
    .CNT_W(CNT_W), .WRAP(WRAP), .THRESH(THRESH), .LOAD(LOAD), .DOWN_W(DOWN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hsyncTick(hsyncTick), .vsyncTick(vsyncTick),
    .ackTick(ackTick), .clearTick(clearTick),
    .lineCount(lineCount), .strobes(strobes)
  );

  scanline_irq_datapath #(
    .CNT_W(CNT_W), .ACK_BIT(ACK_BIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .readTick(readTick),
    .lineCount(lineCount), .irqReq(irqReq), .irqChanged(irqChanged)
  );

  assert_rise_needs_hsync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqReq) |-> $past(hsyncTick));

  assert_ack_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ackTick |=> !irqReq);

endmodule

// File: tb/scanline_irq_timer_test.sv
`timescale 1ns/1ps
module scanline_irq_timer_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsyncTick = 1'b0, vsyncTick = 1'b0, ackTick = 1'b0, clearTick = 1'b0, readTick = 1'b0;
  logic irqReq, irqChanged;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scanline_irq_timer uut (
    .clk(clk), .rst_n(rst_n), .hsyncTick(hsyncTick), .vsyncTick(vsyncTick),
    .ackTick(ackTick), .clearTick(clearTick), .readTick(readTick),
    .irqReq(irqReq), .irqChanged(irqChanged)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle of strobes; outputs are sampled at the following negedge.
  task automatic tick(input logic h, input logic v, input logic a, input logic c, input logic r);
    @(negedge clk);
    hsyncTick = h; vsyncTick = v; ackTick = a; clearTick = c; readTick = r;
    @(negedge clk);
    hsyncTick = 0; vsyncTick = 0; ackTick = 0; clearTick = 0; readTick = 0;
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) tick(1, 0, 0, 0, 0);
  endtask

  // Acknowledge and record the level, leaving the request low and settled.
  task automatic settle();
    tick(0, 0, 1, 0, 0);
    tick(0, 0, 0, 0, 1);
  endtask

  // From count 0: 51 lines stay quiet, the 52nd raises.
  task automatic full_period(input string req);
    lines(51);
    chk(req, irqReq, 1'b0);
    lines(1);
    chk(req, irqReq, 1'b1);
    settle();
  endtask

  task automatic test_reset();
    chk("R1", irqReq, 1'b0);
    chk("R1", irqChanged, 1'b0);
  endtask

  task automatic test_period();
    lines(51);
    chk("R2", irqReq, 1'b0);
    tick(1, 0, 0, 0, 1);           // R9: read coincides with the raise
    chk("R2", irqReq, 1'b1);
    chk("R9", irqChanged, 1'b1);
    tick(0, 0, 0, 0, 1);
    chk("R9", irqChanged, 1'b0);
    chk("R9", irqReq, 1'b1);
    tick(0, 0, 1, 0, 0);
    chk("R3", irqReq, 1'b0);
    chk("R9", irqChanged, 1'b1);
    tick(0, 0, 0, 0, 1);
    chk("R9", irqChanged, 1'b0);
    full_period("R2");
  endtask

  task automatic test_late_ack();
    lines(40);
    tick(0, 0, 1, 0, 0);           // count 40 -> 8
    lines(43);
    chk("R3", irqReq, 1'b0);
    lines(1);
    chk("R3", irqReq, 1'b1);
    settle();
  endtask

  task automatic test_expire_high();
    lines(35);
    tick(0, 1, 0, 0, 0);
    lines(1);
    chk("R4", irqReq, 1'b0);
    lines(1);                      // count 37 at expiry
    chk("R4", irqReq, 1'b1);
    settle();
    full_period("R4");
  endtask

  task automatic test_expire_low();
    lines(10);
    tick(0, 1, 0, 0, 0);
    lines(2);                      // count 12 at expiry
    chk("R5", irqReq, 1'b0);
    full_period("R5");
  endtask

  task automatic test_coincide();
    lines(50);
    tick(0, 1, 0, 0, 0);
    lines(1);
    chk("R6", irqReq, 1'b0);
    lines(1);                      // wrap and expiry together
    chk("R6", irqReq, 1'b1);
    settle();
    chk("R6", irqReq, 1'b0);
    full_period("R6");
  endtask

  task automatic test_reload();
    lines(33);
    tick(0, 1, 0, 0, 0);
    lines(1);
    tick(0, 1, 0, 0, 0);           // reload while one line remains
    lines(1);
    chk("R10", irqReq, 1'b0);
    lines(1);
    chk("R10", irqReq, 1'b1);
    settle();
    full_period("R10");
  endtask

  task automatic test_clear();
    lines(30);
    tick(1, 0, 0, 1, 0);
    chk("R7", irqReq, 1'b0);
    full_period("R7");
    lines(51);
    lines(1);
    chk("R7", irqReq, 1'b1);
    tick(0, 0, 0, 1, 0);
    chk("R7", irqReq, 1'b0);
    tick(0, 0, 0, 0, 1);
    full_period("R7");
  endtask

  task automatic test_ack_race();
    lines(51);
    tick(1, 0, 1, 0, 0);
    chk("R8", irqReq, 1'b0);
    tick(0, 0, 0, 0, 1);
    full_period("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_period();
    test_late_ack();
    test_expire_high();
    test_expire_low();
    test_coincide();
    test_reload();
    test_clear();
    test_ack_race();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule